// File: doc/BRIEF.md
# CRC-4 Frame Protector

This block guards 16-bit command and status words with a 4-bit cyclic check built on the generator x^4 + x + 1. On the outgoing side a 12-bit payload becomes a 16-bit frame. The payload sits in the upper twelve bits, most significant first. The lower four bits carry the complement of the division remainder. On the incoming side a received 16-bit frame is judged valid or corrupt.

Two independent paths are offered. The parallel path is purely combinational and is built from exclusive-OR reductions only. It generates a frame and checks another frame at the same time. The serial path takes one bit per clock, most significant bit first, after a start strobe. It raises a one-clock completion pulse once the last bit has been taken, and the result stays on its outputs until the next start.

Top module: `crc4_frame_unit`

## Requirements
- R1: `par_crc` is the remainder of dividing `par_msg` followed by four zero bits by 10011 (modulo 2); `par_frame[15:4]` equals `par_msg` and `par_frame[3:0]` equals the bitwise complement of `par_crc`.
- R2: For `par_msg` = 110000010000 (0xC10) the remainder is 1101 (0xD) and the frame is 1100000100000010 (0xC102); the serial generate run gives the same remainder.
- R3: `par_rx_ok` is 1 exactly when the received frame, with its low four bits complemented, leaves remainder 0000 on division by 10011; 0xC102 is reported valid.
- R4: Flipping any single one of the 16 bits of a valid frame makes both the parallel and the serial check report invalid.
- R5: A `ser_start` pulse clears the shift register and the bit counter, and it wins over a bit presented in the same cycle; bits with `ser_bit_en` high are taken only after a start and before completion.
- R6: In generate mode (`ser_mode` = 0) the twelfth accepted bit completes the run: `ser_done` is high for exactly the one cycle after the clock edge that took that bit, and `ser_crc` then equals `par_crc` for the same message.
- R7: In check mode (`ser_mode` = 1) sixteen bits complete the run; the last four are complemented inside the block, and `ser_ok` is 1 only if the remainder is zero.
- R8: After completion, `ser_crc` and `ser_ok` hold their values and further bits are ignored until the next start.
- R9: `rst_n` low at a rising clock edge clears `ser_done`, `ser_ok`, `ser_crc` and the bit counter.
- R10: A generate-mode run always finishes with `ser_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the serial path |
| rst_n | input | 1 | Synchronous reset, active low |
| par_msg | input | 12 | Payload for the parallel generator |
| par_crc | output | 4 | Uncomplemented remainder of `par_msg` |
| par_frame | output | 16 | Payload followed by the complemented remainder |
| par_rx_frame | input | 16 | Received frame for the parallel checker |
| par_rx_ok | output | 1 | High when `par_rx_frame` is valid |
| ser_start | input | 1 | Clears the serial engine and begins a run |
| ser_mode | input | 1 | Run mode latched at start: 0 generate, 1 check |
| ser_bit_en | input | 1 | Qualifies `ser_bit` in this cycle |
| ser_bit | input | 1 | Serial data bit, most significant first |
| ser_done | output | 1 | One-cycle pulse after the last bit of a run |
| ser_crc | output | 4 | Serial remainder, held after completion |
| ser_ok | output | 1 | Check-mode verdict, held after completion |

## Verification
A corrupted tap in the exclusive-OR mask shows up combinationally on `par_crc` for every payload that uses the affected bit. The full payload sweep therefore catches it in the same time step as the stimulus. A wrong shift-register or counter state shows at `ser_done` one cycle after the final bit: the pulse comes early, comes late or is missing. It also shows as a remainder that disagrees with the parallel path for the same payload. A hold fault appears on the first cycle after completion, as a change on `ser_crc` while extra bits keep arriving.

// File: rtl/crc4_pkg.sv
// Shared constants and types for the CRC-4 frame protector.
// Assumes the generator x^4 + x + 1; POLY holds its low four coefficients.
package crc4_pkg;
    localparam int                 DEF_MSG_W = 12;
    localparam int                 DEF_CRC_W = 4;
    localparam logic [DEF_CRC_W-1:0] DEF_POLY = 4'b0011;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } crc_mode_e;
endpackage

// File: rtl/crc4_xor_tree.sv
// Parallel remainder of (msg * x^CRC_W) mod g, built only from XOR reductions.
// Each remainder bit XORs the message bits whose weight x^(j+CRC_W) mod g
// has that bit set; the masks are constants computed at elaboration.
// Assumes CRC_W >= 2 and msg[MSG_W-1] is the first (most significant) bit.
module crc4_xor_tree #(
    parameter int                MSG_W = 12,
    parameter int                CRC_W = 4,
    parameter logic [CRC_W-1:0]  POLY  = 4'b0011
) (
    input  logic [MSG_W-1:0] msg,
    output logic [CRC_W-1:0] rem
);
    // x^e mod g, evaluated by repeated multiply-by-x
    function automatic logic [CRC_W-1:0] pow_rem(input int e);
        logic [CRC_W-1:0] r;
        r = {{(CRC_W-1){1'b0}}, 1'b1};
        for (int k = 0; k < e; k++) begin
            r = {r[CRC_W-2:0], 1'b0} ^ (r[CRC_W-1] ? POLY : '0);
        end
        return r;
    endfunction

    // Message bits that feed remainder bit b
    function automatic logic [MSG_W-1:0] tap_mask(input int b);
        logic [MSG_W-1:0] m;
        logic [CRC_W-1:0] w;
        m = '0;
        for (int j = 0; j < MSG_W; j++) begin
            w    = pow_rem(j + CRC_W);
            m[j] = w[b];
        end
        return m;
    endfunction

    for (genvar gi = 0; gi < CRC_W; gi++) begin : g_rem_bit
        localparam logic [MSG_W-1:0] MASK = tap_mask(gi);
        // One XOR reduction per remainder bit
        assign rem[gi] = ^(msg & MASK);
    end
endmodule

// File: rtl/crc4_frame_check.sv
// Parallel validity test for a received frame.
// Because the check bits arrive complemented, the frame is valid exactly when
// the payload's remainder equals the complement of the trailing bits; this is
// the same as a zero remainder after un-inverting and dividing all bits.
module crc4_frame_check #(
    parameter int                MSG_W = 12,
    parameter int                CRC_W = 4,
    parameter logic [CRC_W-1:0]  POLY  = 4'b0011,
    localparam int               FRAME_W = MSG_W + CRC_W
) (
    input  logic [FRAME_W-1:0] frame,
    output logic               ok
);
    logic [CRC_W-1:0] payload_rem;

    crc4_xor_tree #(.MSG_W(MSG_W), .CRC_W(CRC_W), .POLY(POLY)) i_tree (
        .msg (frame[FRAME_W-1:CRC_W]),
        .rem (payload_rem)
    );

    // Zero-remainder test expressed as an XOR compare
    assign ok = ~|(payload_rem ^ ~frame[CRC_W-1:0]);
endmodule

// File: rtl/crc4_serial_engine.sv
// Bit-serial divider: a CRC_W-bit shift register with feedback taps POLY.
// A start clears it and latches the mode; then MSG_W (generate) or
// MSG_W+CRC_W (check) qualified bits are shifted in, MSB first. In check mode
// the final CRC_W bits are complemented on entry. Completion drops busy,
// pulses done for one cycle and freezes the result until the next start.
module crc4_serial_engine
    import crc4_pkg::*;
#(
    parameter int                MSG_W = 12,
    parameter int                CRC_W = 4,
    parameter logic [CRC_W-1:0]  POLY  = 4'b0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_in,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic             done,
    output logic [CRC_W-1:0] rem,
    output logic             ok,
    output crc_mode_e        run_mode
);
    localparam int                CNT_W    = $clog2(MSG_W + CRC_W + 1);
    localparam logic [CNT_W-1:0]  GEN_LAST = CNT_W'(MSG_W - 1);
    localparam logic [CNT_W-1:0]  CHK_LAST = CNT_W'(MSG_W + CRC_W - 1);
    localparam logic [CNT_W-1:0]  INV_FROM = CNT_W'(MSG_W);

    logic [CRC_W-1:0] lfsr_q;
    logic [CRC_W-1:0] lfsr_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;
    logic             busy_q;
    logic             done_q;
    logic             ok_q;
    crc_mode_e        mode_q;
    logic             eff_bit;
    logic             fb;

    // Next shift-register value for the incoming bit
    always_comb begin
        last_idx = (mode_q == MODE_CHK) ? CHK_LAST : GEN_LAST;
        eff_bit  = bit_in ^ ((mode_q == MODE_CHK) && (cnt_q >= INV_FROM));
        fb       = lfsr_q[CRC_W-1] ^ eff_bit;
        lfsr_nxt = {lfsr_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // Run control: start, shift, count and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            mode_q <= MODE_GEN;
        end else if (start) begin
            lfsr_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            mode_q <= crc_mode_e'(mode_in);
        end else begin
            done_q <= 1'b0;
            if (busy_q && bit_en) begin
                lfsr_q <= lfsr_nxt;
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == last_idx) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    ok_q   <= (mode_q == MODE_CHK) && (lfsr_nxt == '0);
                end
            end
        end
    end

    assign done     = done_q;
    assign rem      = lfsr_q;
    assign ok       = ok_q;
    assign run_mode = mode_q;
endmodule

// File: rtl/crc4_frame_unit.sv
// Top of the CRC-4 frame protector.
// Parallel generate (payload -> frame with complemented check bits), parallel
// check of a received frame, and a serial engine for either job.
// Assumes synchronous active-low reset; the parallel paths are unclocked.
module crc4_frame_unit
    import crc4_pkg::*;
#(
    parameter int                MSG_W = DEF_MSG_W,
    parameter int                CRC_W = DEF_CRC_W,
    parameter logic [CRC_W-1:0]  POLY  = DEF_POLY,
    localparam int               FRAME_W = MSG_W + CRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MSG_W-1:0]   par_msg,
    output logic [CRC_W-1:0]   par_crc,
    output logic [FRAME_W-1:0] par_frame,
    input  logic [FRAME_W-1:0] par_rx_frame,
    output logic               par_rx_ok,
    input  logic               ser_start,
    input  logic               ser_mode,
    input  logic               ser_bit_en,
    input  logic               ser_bit,
    output logic               ser_done,
    output logic [CRC_W-1:0]   ser_crc,
    output logic               ser_ok
);
    crc_mode_e eng_mode;

    crc4_xor_tree #(.MSG_W(MSG_W), .CRC_W(CRC_W), .POLY(POLY)) i_gen_tree (
        .msg (par_msg),
        .rem (par_crc)
    );

    // Outgoing frame: payload first, complemented check bits last
    assign par_frame = {par_msg, ~par_crc};

    crc4_frame_check #(.MSG_W(MSG_W), .CRC_W(CRC_W), .POLY(POLY)) i_rx_check (
        .frame (par_rx_frame),
        .ok    (par_rx_ok)
    );

    crc4_serial_engine #(.MSG_W(MSG_W), .CRC_W(CRC_W), .POLY(POLY)) i_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ser_start),
        .mode_in  (ser_mode),
        .bit_en   (ser_bit_en),
        .bit_in   (ser_bit),
        .done     (ser_done),
        .rem      (ser_crc),
        .ok       (ser_ok),
        .run_mode (eng_mode)
    );
endmodule

// File: rtl/crc4_frame_unit_chk.sv
// Property checker for crc4_frame_unit, attached by bind below.
module crc4_frame_unit_chk
    import crc4_pkg::*;
#(
    parameter int MSG_W = 12,
    parameter int CRC_W = 4,
    localparam int FRAME_W = MSG_W + CRC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [MSG_W-1:0]   par_msg,
    input logic [FRAME_W-1:0] par_frame,
    input logic [FRAME_W-1:0] par_rx_frame,
    input logic               par_rx_ok,
    input logic               ser_start,
    input logic               ser_done,
    input logic [CRC_W-1:0]   ser_crc,
    input logic               ser_ok,
    input crc_mode_e          mode_q
);
    // R1: payload occupies the upper bits of the outgoing frame
    assert_frame_payload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        par_frame[FRAME_W-1:CRC_W] == par_msg);

    // R3: any frame the generator makes is accepted by the checker
    assert_gen_frame_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (par_rx_frame == par_frame) |-> par_rx_ok);

    // R5: a start cannot be followed directly by completion
    assert_start_no_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |=> !ser_done);

    // R6: completion lasts a single cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_done |=> !ser_done);

    // R8: results frozen after completion unless restarted
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_done && !ser_start) |=> ($stable(ser_crc) && $stable(ser_ok)));

    // R10: generate runs never report a valid verdict
    assert_gen_ok_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_done && mode_q == MODE_GEN) |-> !ser_ok);
endmodule

bind crc4_frame_unit crc4_frame_unit_chk #(.MSG_W(MSG_W), .CRC_W(CRC_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .par_msg      (par_msg),
    .par_frame    (par_frame),
    .par_rx_frame (par_rx_frame),
    .par_rx_ok    (par_rx_ok),
    .ser_start    (ser_start),
    .ser_done     (ser_done),
    .ser_crc      (ser_crc),
    .ser_ok       (ser_ok),
    .mode_q       (eng_mode)
);

// File: tb/test_crc4_frame_unit.sv
// Directed bench for crc4_frame_unit; one task per scenario.
module test_crc4_frame_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] par_msg = '0;
    logic [3:0]  par_crc;
    logic [15:0] par_frame;
    logic [15:0] par_rx_frame = '0;
    logic        par_rx_ok;
    logic        ser_start = 1'b0;
    logic        ser_mode = 1'b0;
    logic        ser_bit_en = 1'b0;
    logic        ser_bit = 1'b0;
    logic        ser_done;
    logic [3:0]  ser_crc;
    logic        ser_ok;

    int total = 0;
    int bad = 0;

    logic       got_done;
    logic       got_early;
    logic [3:0] got_crc;
    logic       got_ok;

    always #4 clk = ~clk;

    crc4_frame_unit i_crc4_frame_unit (
        .clk(clk), .rst_n(rst_n),
        .par_msg(par_msg), .par_crc(par_crc), .par_frame(par_frame),
        .par_rx_frame(par_rx_frame), .par_rx_ok(par_rx_ok),
        .ser_start(ser_start), .ser_mode(ser_mode),
        .ser_bit_en(ser_bit_en), .ser_bit(ser_bit),
        .ser_done(ser_done), .ser_crc(ser_crc), .ser_ok(ser_ok)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Long division of a 16-bit dividend by 10011, remainder returned
    function automatic logic [3:0] ref_rem(input logic [15:0] d);
        for (int i = 15; i >= 4; i--) begin
            if (d[i]) d[i -: 5] = d[i -: 5] ^ 5'b10011;
        end
        return d[3:0];
    endfunction

    function automatic logic [3:0] ref_crc(input logic [11:0] m);
        return ref_rem({m, 4'b0000});
    endfunction

    function automatic logic ref_valid(input logic [15:0] f);
        return ref_rem({f[15:4], ~f[3:0]}) == 4'b0000;
    endfunction

    // Serial run: start, n bits MSB first, sample at the cycle after the last edge
    task automatic ser_run(input logic [15:0] bits, input int n, input logic mode);
        got_early = 1'b0;
        @(negedge clk);
        ser_start = 1'b1; ser_mode = mode; ser_bit_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ser_done) got_early = 1'b1;
            ser_start = 1'b0; ser_bit_en = 1'b1; ser_bit = bits[n-1-i];
        end
        @(negedge clk);
        ser_bit_en = 1'b0;
        got_done = ser_done; got_crc = ser_crc; got_ok = ser_ok;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "done after reset", 32'(ser_done), 32'd0);
        chk("R9", "ok after reset", 32'(ser_ok), 32'd0);
        chk("R9", "crc after reset", 32'(ser_crc), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_example();
        par_msg = 12'hC10; #1;
        chk("R2", "par remainder of 0xC10", 32'(par_crc), 32'hD);
        chk("R2", "frame of 0xC10", 32'(par_frame), 32'hC102);
        par_rx_frame = 16'hC102; #1;
        chk("R3", "0xC102 valid", 32'(par_rx_ok), 32'd1);
        ser_run({4'h0, 12'hC10}, 12, 1'b0);
        chk("R2", "serial remainder of 0xC10", 32'(got_crc), 32'hD);
        ser_run(16'hC102, 16, 1'b1);
        chk("R7", "serial check 0xC102 done", 32'(got_done), 32'd1);
        chk("R7", "serial check 0xC102 ok", 32'(got_ok), 32'd1);
    endtask

    task automatic t_par_sweep();
        for (int m = 0; m < 4096; m++) begin
            logic [15:0] f;
            par_msg = 12'(m); #1;
            chk("R1", "par remainder", 32'(par_crc), 32'(ref_crc(12'(m))));
            chk("R1", "par frame", 32'(par_frame), 32'({12'(m), ~ref_crc(12'(m))}));
            f = {12'(m), ~ref_crc(12'(m))};
            par_rx_frame = f; #1;
            chk("R3", "valid frame accepted", 32'(par_rx_ok), 32'd1);
            for (int b = 0; b < 16; b++) begin
                par_rx_frame = f ^ (16'd1 << b); #1;
                chk("R4", "single-bit error rejected", 32'(par_rx_ok), 32'd0);
            end
            par_rx_frame = {12'(m), 4'(m)}; #1;
            chk("R3", "arbitrary trailer verdict", 32'(par_rx_ok),
                32'(ref_valid({12'(m), 4'(m)})));
        end
    endtask

    task automatic t_ser_sweep();
        for (int m = 0; m < 4096; m++) begin
            ser_run({4'h0, 12'(m)}, 12, 1'b0);
            chk("R6", "no early done", 32'(got_early), 32'd0);
            chk("R6", "done after 12th bit", 32'(got_done), 32'd1);
            chk("R6", "serial equals reference", 32'(got_crc), 32'(ref_crc(12'(m))));
            chk("R10", "gen-mode ok low", 32'(got_ok), 32'd0);
        end
    endtask

    task automatic t_ser_check();
        for (int k = 0; k < 4; k++) begin
            logic [11:0] m;
            logic [15:0] f;
            m = 12'(k * 1237 + 5);
            f = {m, ~ref_crc(m)};
            ser_run(f, 16, 1'b1);
            chk("R7", "no early done in check", 32'(got_early), 32'd0);
            chk("R7", "check valid frame", 32'(got_ok), 32'd1);
            for (int b = 0; b < 16; b++) begin
                ser_run(f ^ (16'd1 << b), 16, 1'b1);
                chk("R4", "serial single-bit error", 32'(got_ok), 32'd0);
                chk("R7", "check done", 32'(got_done), 32'd1);
            end
        end
    endtask

    task automatic t_hold();
        ser_run({4'h0, 12'h5A3}, 12, 1'b0);
        for (int i = 0; i < 4; i++) begin
            ser_bit_en = 1'b1; ser_bit = i[0];
            @(negedge clk);
            chk("R8", "done stays low", 32'(ser_done), 32'd0);
            chk("R8", "crc held", 32'(ser_crc), 32'(ref_crc(12'h5A3)));
            chk("R8", "ok held", 32'(ser_ok), 32'd0);
        end
        ser_bit_en = 1'b0;
    endtask

    task automatic t_restart();
        // Abandon a partial run; start with a bit in the same cycle is ignored
        @(negedge clk);
        ser_start = 1'b1; ser_mode = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            ser_start = 1'b0; ser_bit_en = 1'b1; ser_bit = 1'b1;
        end
        @(negedge clk);
        ser_start = 1'b1; ser_bit_en = 1'b1; ser_bit = 1'b1;
        ser_run({4'h0, 12'h3C7}, 12, 1'b0);
        chk("R5", "restart clears partial run", 32'(got_crc), 32'(ref_crc(12'h3C7)));
        chk("R5", "restart completes", 32'(got_done), 32'd1);
        // Reset mid-run, then bits without a start are ignored
        @(negedge clk);
        ser_start = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ser_start = 1'b0; ser_bit_en = 1'b1; ser_bit = 1'b1;
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9", "crc cleared mid-run", 32'(ser_crc), 32'd0);
        chk("R9", "done cleared mid-run", 32'(ser_done), 32'd0);
        for (int i = 0; i < 14; i++) begin
            ser_bit_en = 1'b1; ser_bit = 1'b1;
            @(negedge clk);
            chk("R5", "bits ignored without start", 32'(ser_done), 32'd0);
        end
        chk("R5", "crc unchanged without start", 32'(ser_crc), 32'd0);
        ser_bit_en = 1'b0;
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_example();
        t_par_sweep();
        t_ser_sweep();
        t_ser_check();
        t_hold();
        t_restart();
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report();
    end
endmodule